// File: doc/BRIEF.md
# Banked Entry Store with Delayed Payload Commit

This block keeps one payload word and one small set of state flags for every entry of a queue. A writer presents an entry index together with a payload word and a flag value. The flags land at the end of the request cycle. The payload first goes into a single pipeline register. One cycle later it is committed into one of several equal banks. Splitting the payload path this way keeps the fan-out of the write decode out of the request cycle.

Two separate qualifiers control the write. `wr_in_valid` governs the flags. `wr_data_qual` governs the payload. A caller can therefore refresh the state flags on every valid request and spend payload write energy only when the upstream stage really carries data.

The read port is a plain mux from the stored arrays. It has no forwarding from the pending register. Callers must not read an entry until two cycles after they asked to write it.

Top module: `entry_store`

## Requirements
- R1: After reset, every entry reads back a payload of zero and flags of zero.
- R2: An entry index selects its bank through its low log2(NUM_BANKS) bits and its row within that bank through the upper bits. A write to one entry never changes another entry, including entries that share its bank (index differing only in bit 3 with 8 banks).
- R3: When `wr_in_valid` is high at a rising edge, the flags of entry `wr_idx` take `wr_flags` at that edge, whatever `wr_data_qual` is.
- R4: When `wr_in_valid` is low, no flag of any entry changes, even if `wr_data_qual` is high.
- R5: When `wr_data_qual` is high in cycle T, the payload is held in the pending register at the end of T and committed to its bank at the end of T+1. A read in cycle T+2 returns it. No read of an entry may occur while that entry's write is pending.
- R6: When `wr_data_qual` is low, no payload changes, even if `wr_in_valid` is high.
- R7: Payload requests in consecutive cycles, to the same bank or to different banks, all commit in request order, one cycle apart.
- R8: `rd_data` and `rd_flags` follow `rd_idx` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in_valid | input | 1 | Request valid; qualifies the flag update |
| wr_data_qual | input | 1 | Payload qualifier; qualifies the payload write |
| wr_idx | input | log2(NUM_ENTRIES) | Entry addressed by the write request |
| wr_data | input | DATA_W | Payload word to store |
| wr_flags | input | FLAG_W | State flag value to store |
| rd_idx | input | log2(NUM_ENTRIES) | Entry to read |
| rd_data | output | DATA_W | Payload of entry `rd_idx` |
| rd_flags | output | FLAG_W | Flags of entry `rd_idx` |

## Verification
The hardest cases come from the split qualifiers. The stimulus has to raise one qualifier without the other, then show at the read port that only one of the two arrays moved. The vector table pairs flag-only and payload-only requests on entries that already hold known values, so an unwanted write shows up as a changed readback. Pairs of indices that fall in the same bank are written back to back. Each write is followed by a read of its bank neighbour, which exposes any row-decode error. Reads are always steered away from the entry whose commit is still pending, and the read of the written entry is placed in the cycle two after the request.

// File: rtl/estore_pkg.sv
package estore_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/estore_wr_stage.sv
module estore_wr_stage #(
   parameter int IDX_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              pend_vld_o,
   output logic [IDX_W-1:0]  pend_idx_o,
   output logic [DATA_W-1:0] pend_data_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld_o  <= 1'b0;
         pend_idx_o  <= '0;
         pend_data_o <= '0;
      end else begin
         pend_vld_o <= qual_i;
         if (qual_i) begin
            pend_idx_o  <= idx_i;
            pend_data_o <= data_i;
         end
      end
   end

endmodule

// File: rtl/estore_data_bank.sv
module estore_data_bank #(
   parameter int ROWS   = 4,
   parameter int DATA_W = 32,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic [ROW_W-1:0]       row_i,
   input  logic [DATA_W-1:0]      din_i,
   output logic [ROWS*DATA_W-1:0] rows_o
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cell_q <= '0;
         else if (we_i && (row_i == ROW_W'(r)))
            cell_q <= din_i;
      end
      assign rows_o[r*DATA_W +: DATA_W] = cell_q;
   end

endmodule

// File: rtl/estore_flag_array.sv
module estore_flag_array #(
   parameter int ENTRIES = 32,
   parameter int FLAG_W  = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [FLAG_W-1:0]         din_i,
   output logic [ENTRIES*FLAG_W-1:0] flags_o
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [FLAG_W-1:0] fl_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            fl_q <= '0;
         else if (we_i && (idx_i == IDX_W'(e)))
            fl_q <= din_i;
      end
      assign flags_o[e*FLAG_W +: FLAG_W] = fl_q;
   end

endmodule

// File: rtl/entry_store.sv
module entry_store #(
   parameter int NUM_ENTRIES = 32,
   parameter int NUM_BANKS   = 8,
   parameter int DATA_W      = 32,
   parameter int FLAG_W      = 4,
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int BANK_W     = $clog2(NUM_BANKS),
   localparam int ROWS       = NUM_ENTRIES / NUM_BANKS,
   localparam int ROW_W      = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_in_valid,
   input  logic              wr_data_qual,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [FLAG_W-1:0] rd_flags
);

   if (!estore_pkg::is_pow2(NUM_BANKS) || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (!estore_pkg::is_pow2(NUM_ENTRIES) || ROWS < 2) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two holding at least two rows per bank");
   end

   // pending write register (request cycle -> commit cycle)
   logic              pend_vld;
   logic [IDX_W-1:0]  pend_idx;
   logic [DATA_W-1:0] pend_data;

   estore_wr_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_wr_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_i     (wr_data_qual),
      .idx_i      (wr_idx),
      .data_i     (wr_data),
      .pend_vld_o (pend_vld),
      .pend_idx_o (pend_idx),
      .pend_data_o(pend_data)
   );

   logic [BANK_W-1:0] pend_bank;
   logic [ROW_W-1:0]  pend_row;
   assign pend_bank = pend_idx[BANK_W-1:0];
   assign pend_row  = pend_idx[IDX_W-1:BANK_W];

   logic [ROWS*DATA_W-1:0]        bank_rows [NUM_BANKS];
   logic [NUM_ENTRIES*DATA_W-1:0] data_flat;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_we;
      assign bank_we = pend_vld && (pend_bank == BANK_W'(b));

      estore_data_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_i   (bank_we),
         .row_i  (pend_row),
         .din_i  (pend_data),
         .rows_o (bank_rows[b])
      );

      for (genvar r = 0; r < ROWS; r++) begin : g_map
         assign data_flat[(r*NUM_BANKS+b)*DATA_W +: DATA_W] =
            bank_rows[b][r*DATA_W +: DATA_W];
      end
   end

   logic [NUM_ENTRIES*FLAG_W-1:0] flag_flat;

   estore_flag_array #(.ENTRIES(NUM_ENTRIES), .FLAG_W(FLAG_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_in_valid),
      .idx_i   (wr_idx),
      .din_i   (wr_flags),
      .flags_o (flag_flat)
   );

   // read path: bank mux, then row mux
   logic [BANK_W-1:0]      rd_bank;
   logic [ROW_W-1:0]       rd_row;
   logic [ROWS*DATA_W-1:0] rd_bank_rows;

   assign rd_bank = rd_idx[BANK_W-1:0];
   assign rd_row  = rd_idx[IDX_W-1:BANK_W];

   always_comb begin
      rd_bank_rows = bank_rows[0];
      for (int b = 1; b < NUM_BANKS; b++) begin
         if (rd_bank == BANK_W'(b))
            rd_bank_rows = bank_rows[b];
      end
   end

   assign rd_data  = rd_bank_rows[rd_row*DATA_W +: DATA_W];
   assign rd_flags = flag_flat[rd_idx*FLAG_W +: FLAG_W];

endmodule

// File: rtl/estore_chk.sv
module estore_chk #(
   parameter int NUM_ENTRIES = 32,
   parameter int DATA_W      = 32,
   parameter int FLAG_W      = 4,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_in_valid,
   input logic                          wr_data_qual,
   input logic [IDX_W-1:0]              wr_idx,
   input logic [DATA_W-1:0]             wr_data,
   input logic [FLAG_W-1:0]             wr_flags,
   input logic [IDX_W-1:0]              rd_idx,
   input logic                          pend_vld,
   input logic [IDX_W-1:0]              pend_idx,
   input logic [DATA_W-1:0]             pend_data,
   input logic [NUM_ENTRIES*DATA_W-1:0] data_flat,
   input logic [NUM_ENTRIES*FLAG_W-1:0] flag_flat
);

   logic [IDX_W-1:0] last_pidx, last_widx;
   always_ff @(posedge clk) begin
      last_pidx <= pend_idx;
      last_widx <= wr_idx;
   end

   logic [DATA_W-1:0] data_at_last_pidx;
   logic [FLAG_W-1:0] flags_at_last_widx;
   assign data_at_last_pidx  = data_flat[last_pidx*DATA_W +: DATA_W];
   assign flags_at_last_widx = flag_flat[last_widx*FLAG_W +: FLAG_W];

   // R5
   read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld |-> (rd_idx != pend_idx));

   // R5
   pipe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_qual |=> (pend_vld && pend_idx == $past(wr_idx)
                        && pend_data == $past(wr_data)));

   // R6
   pipe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data_qual |=> !pend_vld);

   // R5
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld |=> (data_at_last_pidx == $past(pend_data)));

   // R6
   payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld |=> $stable(data_flat));

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in_valid |=> (flags_at_last_widx == $past(wr_flags)));

   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_in_valid |=> $stable(flag_flat));

endmodule

bind entry_store estore_chk #(
   .NUM_ENTRIES(NUM_ENTRIES),
   .DATA_W     (DATA_W),
   .FLAG_W     (FLAG_W)
) u_estore_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_in_valid (wr_in_valid),
   .wr_data_qual(wr_data_qual),
   .wr_idx      (wr_idx),
   .wr_data     (wr_data),
   .wr_flags    (wr_flags),
   .rd_idx      (rd_idx),
   .pend_vld    (pend_vld),
   .pend_idx    (pend_idx),
   .pend_data   (pend_data),
   .data_flat   (data_flat),
   .flag_flat   (flag_flat)
);

// File: tb/entry_store_bench.sv
module entry_store_bench;

   localparam int N  = 32;
   localparam int DW = 32;
   localparam int FW = 4;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_in_valid = 1'b0;
   logic          wr_data_qual = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [FW-1:0] wr_flags = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [DW-1:0] rd_data;
   logic [FW-1:0] rd_flags;

   always #4 clk = ~clk;   // 125 MHz

   entry_store u_entry_store (
      .clk(clk), .rst_n(rst_n),
      .wr_in_valid(wr_in_valid), .wr_data_qual(wr_data_qual),
      .wr_idx(wr_idx), .wr_data(wr_data), .wr_flags(wr_flags),
      .rd_idx(rd_idx), .rd_data(rd_data), .rd_flags(rd_flags)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [DW-1:0] m_data  [N];
   logic [FW-1:0] m_flags [N];

   // {in_valid, qual, idx[4:0], data[31:0], flags[3:0]}
   localparam int NV = 10;
   localparam logic [42:0] VEC [NV] = '{
      {1'b1, 1'b1, 5'd0,  32'hA5A5_0001, 4'h3},
      {1'b1, 1'b1, 5'd31, 32'hDEAD_001F, 4'hF},
      {1'b1, 1'b1, 5'd7,  32'h0000_0707, 4'h1},
      {1'b1, 1'b1, 5'd8,  32'h0000_0808, 4'h2},
      {1'b0, 1'b1, 5'd8,  32'h1111_8888, 4'hC},
      {1'b1, 1'b0, 5'd7,  32'hBAD0_0007, 4'h9},
      {1'b0, 1'b0, 5'd31, 32'hFFFF_FFFF, 4'h0},
      {1'b1, 1'b1, 5'd16, 32'h1616_1616, 4'h6},
      {1'b1, 1'b1, 5'd24, 32'h2424_2424, 4'h8},
      {1'b1, 1'b1, 5'd15, 32'h1515_1515, 4'h5}
   };

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_chk(input logic [IW-1:0] idx, input string dtag, input string ftag);
      rd_idx = idx;
      #1;
      chk(dtag, rd_data, m_data[idx]);
      chk(ftag, {28'd0, rd_flags}, {28'd0, m_flags[idx]});
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_data[i]  = '0;
         m_flags[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset contents
      @(negedge clk);
      read_chk(5'd0,  "R1 data", "R1 flags");
      read_chk(5'd13, "R1 data", "R1 flags");
      read_chk(5'd31, "R1 data", "R1 flags");

      // vector walk: request, hold one cycle, read at T+2
      for (int v = 0; v < NV; v++) begin
         logic          iv, q;
         logic [IW-1:0] ix;
         logic [DW-1:0] dt;
         logic [FW-1:0] fl;
         {iv, q, ix, dt, fl} = VEC[v];
         @(negedge clk);
         wr_in_valid = iv; wr_data_qual = q;
         wr_idx = ix; wr_data = dt; wr_flags = fl;
         rd_idx = ix ^ 5'd1;
         @(negedge clk);
         wr_in_valid = 1'b0; wr_data_qual = 1'b0;
         @(negedge clk);
         if (q)  m_data[ix]  = dt;
         if (iv) m_flags[ix] = fl;
         read_chk(ix, q ? "R5 payload written" : "R6 payload kept",
                      iv ? "R3 flags written" : "R4 flags kept");
         // R2: same-bank neighbour untouched
         read_chk(ix ^ 5'd8, "R2 neighbour data", "R2 neighbour flags");
      end

      // R7: back-to-back requests, same bank (5, 13) then another bank (20)
      @(negedge clk);
      rd_idx = 5'd2;
      wr_in_valid = 1'b1; wr_data_qual = 1'b1;
      wr_idx = 5'd5;  wr_data = 32'h0505_AAAA; wr_flags = 4'h5;
      @(negedge clk);
      wr_idx = 5'd13; wr_data = 32'h1313_BBBB; wr_flags = 4'hD;
      @(negedge clk);
      wr_idx = 5'd20; wr_data = 32'h2020_CCCC; wr_flags = 4'h4;
      @(negedge clk);
      wr_in_valid = 1'b0; wr_data_qual = 1'b0;
      m_data[5]  = 32'h0505_AAAA; m_flags[5]  = 4'h5;
      m_data[13] = 32'h1313_BBBB; m_flags[13] = 4'hD;
      m_data[20] = 32'h2020_CCCC; m_flags[20] = 4'h4;
      read_chk(5'd5,  "R7 first data",  "R7 first flags");
      read_chk(5'd13, "R7 second data", "R7 second flags");
      @(negedge clk);
      read_chk(5'd20, "R7 third data",  "R7 third flags");

      // R8: read follows rd_idx with no clock edge in between
      read_chk(5'd0,  "R8 data", "R8 flags");
      read_chk(5'd31, "R8 data", "R8 flags");
      read_chk(5'd16, "R8 data", "R8 flags");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule